// File: doc/BRIEF.md
# Banked General Register File

This block holds sixteen general registers of 32 bits for a processor core, together with the status word that controls them. Registers 0 to 7 exist twice, once in each of two banks. Registers 8 to 15 exist once and are shared. The status word selects which of the two low banks the core sees. The second bank is active only when the privileged-mode bit and the bank-select bit are both set. In every other case the first bank is active.

The core reads through two combinational read ports and writes through one write port. It updates the status word in one of two ways. A full write replaces every defined field. A single-flag write changes one of the four arithmetic flags. A side port reaches the bank that is currently hidden, so that privileged code can save or restore it. A status write that flips the active bank takes effect at the same clock edge as the write. From the next cycle on, the low eight registers show the contents of the newly selected bank. The contents of the bank that was left stay intact, and the side port reaches them.

Top module: `banked_regfile`

## Requirements
- R1: After reset, the status word reads 0 and every register of both banks and of the shared set reads 0.
- R2: The status word keeps only its defined fields: flag T at bit 0, flag S at bit 1, interrupt level at bits 7:4, flag Q at bit 8, flag M at bit 9, block bit at bit 28, bank-select bit at bit 29 and privileged-mode bit at bit 30. Every other bit reads 0.
- R3: The second bank is active exactly when bit 30 and bit 29 of the status word are both 1. Otherwise the first bank is active.
- R4: When a status write changes the active bank, reads of registers 0 to 7 in the next cycle return the contents of the newly active bank. The bank that was left keeps its values.
- R5: Registers 8 to 15 are the same in both banks, and a bank change leaves them unchanged.
- R6: When a general write and a bank-changing status write occur in the same cycle, the general write lands in the newly active bank.
- R7: The side port reads and writes entry 0 to 7 of the bank that is not active. A side write never changes what the read ports return for the active bank.
- R8: A flag write (select 0 = T, 1 = S, 2 = Q, 3 = M) changes only that bit and never changes the active bank.
- R9: When a full status write and a flag write occur in the same cycle, the full write alone decides the new status word.
- R10: The read ports are combinational and independent of each other. A general write becomes visible on them in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | General register write number |
| wr_data | input | 32 | General register write data |
| sr_wr_en | input | 1 | Full status write enable |
| sr_wr_data | input | 32 | Full status write value |
| flag_wr_en | input | 1 | Single-flag write enable |
| flag_sel | input | 2 | Flag select: 0 T, 1 S, 2 Q, 3 M |
| flag_val | input | 1 | New flag value |
| sr_rd_data | output | 32 | Current status word |
| alt_idx | input | 3 | Entry of the inactive bank |
| alt_wr_en | input | 1 | Inactive-bank write enable |
| alt_wr_data | input | 32 | Inactive-bank write data |
| alt_rd_data | output | 32 | Inactive-bank read data |

## Verification
The hardest case to reach is a single cycle that carries a general write to a low register together with a status write that flips the bank. Getting the destination wrong leaves no trace until the bank is flipped back. The stimulus fills both banks with distinct values first. It then issues the combined write and checks two things: the active bank through a read port, and the untouched old bank through the side port. It also runs the near cases, a flag write and a write that sets only one of the two selecting bits, to show that neither moves the bank.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32,
  parameter int NREG = 16,
  parameter int NBANKED = 8,
  localparam int IW = $clog2(NREG),
  localparam int BW = $clog2(NBANKED)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [IW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          sr_wr_en,
  input  logic [31:0]   sr_wr_data,
  input  logic          flag_wr_en,
  input  logic [1:0]    flag_sel,
  input  logic          flag_val,
  output logic [31:0]   sr_rd_data,
  input  logic [BW-1:0] alt_idx,
  input  logic          alt_wr_en,
  input  logic [DW-1:0] alt_wr_data,
  output logic [DW-1:0] alt_rd_data
);
  localparam int NSHARED = NREG - NBANKED;
  localparam int SW = (NSHARED > 1) ? $clog2(NSHARED) : 1;
  localparam int B_T = 0, B_S = 1, B_IM = 4, B_Q = 8, B_M = 9;
  localparam int B_BL = 28, B_RB = 29, B_MD = 30;
  localparam logic [31:0] SR_KEEP = (32'h1 << B_T) | (32'h1 << B_S) | (32'hF << B_IM) |
                                    (32'h1 << B_Q) | (32'h1 << B_M) | (32'h1 << B_BL) |
                                    (32'h1 << B_RB) | (32'h1 << B_MD);

  logic [31:0] sr_q, sr_d;
  logic [1:0][NBANKED-1:0][DW-1:0] bank_q;
  logic [NSHARED-1:0][DW-1:0] shared_q;
  logic act_q, act_d;

  always_comb begin
    sr_d = sr_q;
    if (sr_wr_en) sr_d = sr_wr_data & SR_KEEP;
    else if (flag_wr_en) begin
      case (flag_sel)
        2'd0: sr_d[B_T] = flag_val;
        2'd1: sr_d[B_S] = flag_val;
        2'd2: sr_d[B_Q] = flag_val;
        default: sr_d[B_M] = flag_val;
      endcase
    end
  end

  assign act_q = sr_q[B_MD] & sr_q[B_RB];
  assign act_d = sr_d[B_MD] & sr_d[B_RB];

  function automatic logic [SW-1:0] shared_slot(input logic [IW-1:0] idx);
    return SW'(idx - IW'(NBANKED));
  endfunction

  function automatic logic [DW-1:0] read_gpr(input logic [IW-1:0] idx);
    if (int'(idx) < NBANKED) return bank_q[act_q][idx[BW-1:0]];
    return shared_q[shared_slot(idx)];
  endfunction

  assign rd_a_data   = read_gpr(rd_a_idx);
  assign rd_b_data   = read_gpr(rd_b_idx);
  assign sr_rd_data  = sr_q;
  assign alt_rd_data = bank_q[~act_q][alt_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q     <= '0;
      bank_q   <= '0;
      shared_q <= '0;
    end else begin
      sr_q <= sr_d;
      if (wr_en) begin
        if (int'(wr_idx) < NBANKED) bank_q[act_d][wr_idx[BW-1:0]] <= wr_data;
        else shared_q[shared_slot(wr_idx)] <= wr_data;
      end
      if (alt_wr_en) bank_q[~act_d][alt_idx] <= alt_wr_data;
    end
  end

  // R9: a full write decides the status word even beside a flag write
  p_full_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_en |=> sr_rd_data == ($past(sr_wr_data) & SR_KEEP));

  p_flag_keeps_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_en && !sr_wr_en) |=> act_q == $past(act_q));

  p_write_new_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) < NBANKED) |=>
      bank_q[$past(act_d)][$past(wr_idx[BW-1:0])] == $past(wr_data));

  p_side_write_hidden_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alt_wr_en |=> bank_q[!$past(act_d)][$past(alt_idx)] == $past(alt_wr_data));

  p_shared_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_en && act_d != act_q && !wr_en) |=> shared_q == $past(shared_q));

  p_old_bank_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_d != act_q && !alt_wr_en) |=> bank_q[$past(act_q)] == $past(bank_q[act_q]));
endmodule

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
  logic clk = 0, rst_n = 0;
  logic [3:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0, sr_wr_data = 0, sr_rd_data;
  logic wr_en = 0, sr_wr_en = 0, flag_wr_en = 0, flag_val = 0, alt_wr_en = 0;
  logic [1:0] flag_sel = 0;
  logic [2:0] alt_idx = 0;
  logic [31:0] alt_wr_data = 0, alt_rd_data;

  banked_regfile u_banked_regfile (.*);

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] mb [2][8];
  logic [31:0] ms [8];
  logic [31:0] msr;
  localparam logic [31:0] KEEP = 32'h7000_03F3;

  int q_sel[$];
  logic [31:0] q_exp[$];
  string q_tag[$];

  function automatic bit bank_of(input logic [31:0] s);
    return s[30] & s[29];
  endfunction

  function automatic logic [31:0] model_rd(input int idx);
    if (idx < 8) return mb[bank_of(msr)][idx];
    return ms[idx-8];
  endfunction

  always @(negedge clk) begin
    while (q_sel.size() > 0) begin
      int s;
      logic [31:0] e, a;
      string t;
      s = q_sel.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
      case (s)
        0: a = rd_a_data;
        1: a = rd_b_data;
        2: a = sr_rd_data;
        default: a = alt_rd_data;
      endcase
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s port%0d actual=%h expected=%h", t, s, a, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    wr_en = 0; sr_wr_en = 0; flag_wr_en = 0; alt_wr_en = 0;
  endtask

  task automatic cycle(input bit g, input int gi, input logic [31:0] gv,
                       input bit s, input logic [31:0] sv,
                       input bit f, input int fs, input bit fv,
                       input bit a, input int ai, input logic [31:0] av);
    logic [31:0] nsr;
    bit nb;
    int pos[4] = '{0, 1, 8, 9};
    nsr = msr;
    if (s) nsr = sv & KEEP;
    else if (f) nsr[pos[fs]] = fv;
    nb = bank_of(nsr);
    wr_en = g; wr_idx = 4'(gi); wr_data = gv;
    sr_wr_en = s; sr_wr_data = sv;
    flag_wr_en = f; flag_sel = 2'(fs); flag_val = fv;
    alt_wr_en = a; alt_idx = 3'(ai); alt_wr_data = av;
    tick();
    if (g) begin
      if (gi < 8) mb[nb][gi] = gv; else ms[gi-8] = gv;
    end
    if (a) mb[!nb][ai] = av;
    msr = nsr;
  endtask

  task automatic gwr(input int i, input logic [31:0] v);
    cycle(1, i, v, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic swr(input logic [31:0] v);
    cycle(0, 0, 0, 1, v, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic fwr(input int fs, input bit fv);
    cycle(0, 0, 0, 0, 0, 1, fs, fv, 0, 0, 0);
  endtask

  task automatic probe(input int port, input int idx, input string tag);
    logic [31:0] e;
    case (port)
      0: begin rd_a_idx = 4'(idx); e = model_rd(idx); end
      1: begin rd_b_idx = 4'(idx); e = model_rd(idx); end
      2: e = msr;
      default: begin alt_idx = 3'(idx); e = mb[!bank_of(msr)][idx]; end
    endcase
    q_sel.push_back(port); q_exp.push_back(e); q_tag.push_back(tag);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mb[0][i] = 0; mb[1][i] = 0; ms[i] = 0; end
    msr = 0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk); #1;
    probe(2, 0, "R1 status");
    probe(0, 0, "R1 r0");
    probe(1, 15, "R1 r15");
    probe(3, 7, "R1 hidden bank");
    for (int i = 0; i < 16; i++) gwr(i, 32'h100 + i);
    probe(0, 3, "R10 r3");
    probe(1, 12, "R10 r12");
    gwr(6, 32'hC0DE_0006);
    rd_a_idx = 4'd6; rd_b_idx = 4'd9;
    probe(0, 6, "R10 port A after write");
    probe(1, 9, "R10 port B independent");
    swr(32'hFFFF_FFFF);
    probe(2, 0, "R2 masked status");
    probe(0, 0, "R3 second bank r0");
    probe(3, 0, "R4 old bank via side port");
    probe(1, 8, "R5 shared r8 after change");
    gwr(3, 32'hAAAA);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 5, 32'h5555);
    probe(0, 5, "R7 side write hidden from reads");
    probe(3, 5, "R7 side read of hidden entry");
    swr(32'h4000_0000);
    probe(0, 5, "R4 first bank r5");
    probe(0, 3, "R4 first bank r3");
    probe(3, 3, "R4 second bank kept r3");
    swr(32'h2000_0000);
    probe(0, 0, "R3 select bit alone keeps first bank");
    swr(32'h0000_00F0);
    probe(2, 0, "R2 interrupt level field");
    swr(32'h6000_0000);
    fwr(0, 1); fwr(1, 1); fwr(2, 1); fwr(3, 1);
    probe(2, 0, "R8 flags set");
    probe(0, 3, "R8 bank kept after flags");
    fwr(2, 0);
    probe(2, 0, "R8 clear Q only");
    cycle(1, 2, 32'hBEEF, 1, 32'h0, 0, 0, 0, 0, 0, 0);
    probe(0, 2, "R6 write into new bank");
    probe(3, 2, "R6 old bank untouched");
    probe(1, 14, "R5 shared r14");
    cycle(0, 0, 0, 1, 32'h0000_0010, 1, 0, 1, 0, 0, 0);
    probe(2, 0, "R9 full write wins");
    @(negedge clk); #1;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule